// File: doc/BRIEF.md
# Analog Comparator Control Wrapper

This block is the digital side of an on-chip voltage comparator. Software reaches it through three byte-wide registers on a simple peripheral bus: a primary control register, a secondary control register and a port input-disable register. From these registers the block drives the analog front end: comparator power, reference level, the signal path that receives the reference, the two input connect switches and the input exchange switch.

The raw comparator decision enters asynchronously. It passes through a synchronizer and an optional three-sample stability filter, and then appears as a read-only status bit. A software-chosen edge of that status sets a sticky event flag, and the flag is gated with an enable to form the interrupt request. The exchange switch swaps the comparator inputs, so software can take two readings and cancel the comparator offset. The input-disable register lets software switch off port input buffers whose pins carry analog levels, so that those buffers draw no supply current.

Top module: `cmp_ctrl`

## Requirements
- R1: After reset every register reads 0x00, and irq_o, pad_in_dis_o and all analog control outputs are 0.
- R2: The primary register (0x59) reads back as written: bit0 event flag, bit1 interrupt enable, bit2 edge select, bit3 power on, bits5:4 reference select, bit6 reference route, bit7 exchange.
- R3: The secondary register (0x5A) holds bit1 filter enable, bit2 connect input 0 and bit3 connect input 1. Bits 7:4 are plain storage that read back as written. Bit0 shows the comparator status and ignores writes.
- R4: With edge select 0, a rising edge of the status sets the flag. With edge select 1, a falling edge sets it. The opposite edge leaves the flag unchanged.
- R5: ref_drive_o is 1 exactly when reference select is 1, 2 or 3. The reference goes to path 0 when the route bit is 0 and to path 1 when it is 1, and to neither path when reference select is 0.
- R6: With the filter off, the status bit follows the comparator input two clock edges after it changes, and the flag sets one edge later.
- R7: With the filter on, the status changes only after three equal consecutive synchronized samples, so a one-cycle pulse never reaches the status or the flag.
- R8: The input-disable register (0x5B) drives pad_in_dis_o bit for bit and reads back as written.
- R9: While power on is 0, the status reads 0 and no edge sets the flag.
- R10: irq_o is flag AND enable. Writing 0 to bit0 clears the flag and writing 1 sets it. An edge in the same cycle as a clearing write leaves the flag set.
- R11: cmp_on_o, in_swap_o, in0_conn_o and in1_conn_o follow their register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus select |
| wr_i | input | 1 | Write strobe, valid with sel_i |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational, 0 when not selected) |
| cmp_raw_i | input | 1 | Asynchronous comparator decision |
| cmp_on_o | output | 1 | Comparator power enable |
| ref_sel_o | output | 2 | Reference level select |
| ref_drive_o | output | 1 | Internal reference source enabled |
| ref_path0_o | output | 1 | Reference switched onto signal path 0 |
| ref_path1_o | output | 1 | Reference switched onto signal path 1 |
| in0_conn_o | output | 1 | Input pin 0 connect switch |
| in1_conn_o | output | 1 | Input pin 1 connect switch |
| in_swap_o | output | 1 | Comparator input exchange |
| pad_in_dis_o | output | 8 | Port input buffer disables |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check that the reference reaches at most one path, that a detected edge always leaves the flag set even against a clearing write, that the flag rises only from an edge or a software write, that no set happens while the comparator is off, and that the filtered status moves only after a run of equal samples. Only the directed scenarios show the exact latencies of the transparent and filtered paths, the choice between rising and falling edges, glitch rejection, and the readback of every register field.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
  typedef struct packed {
    logic       exch;
    logic       route;
    logic [1:0] ref_sel;
    logic       on;
    logic       edge_fall;
    logic       ie;
    logic       flag;
  } ctl1_t;

  typedef struct packed {
    logic [3:0] spare;
    logic       conn1;
    logic       conn0;
    logic       filt_en;
  } ctl2_t;
endpackage

// File: rtl/cmp_ctrl_sampler.sv
module cmp_ctrl_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic on_i,
  input  logic filt_en_i,
  input  logic edge_fall_i,
  output logic out_o,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-2:0]    hist_q;
  logic [FILT_LEN-1:0]    window;
  logic                   smp, filt_q, prev_q;

  assign smp    = sync_q[SYNC_STAGES-1];
  assign window = {hist_q, smp};

  // all sampling state is held clear while the comparator is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (!on_i) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      hist_q <= window[FILT_LEN-2:0];
      if (&window)       filt_q <= 1'b1;
      else if (~|window) filt_q <= 1'b0;
      prev_q <= out_o;
    end
  end

  assign out_o  = on_i & (filt_en_i ? filt_q : smp);
  assign edge_o = on_i & (edge_fall_i ? (prev_q & ~out_o) : (~prev_q & out_o));

  a_r7_filter_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_i && filt_en_i && $past(on_i && filt_en_i) && out_o != $past(out_o))
      |-> ($past(&window) || $past(~|window)));
endmodule

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs
  import cmp_ctrl_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              PORT_W    = 8,
  parameter logic [ADDR_W-1:0] CTL1_ADDR = 'h59,
  parameter logic [ADDR_W-1:0] CTL2_ADDR = 'h5A,
  parameter logic [ADDR_W-1:0] PD_ADDR   = 'h5B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              out_i,
  input  logic              edge_i,
  output ctl1_t             ctl1_o,
  output ctl2_t             ctl2_o,
  output logic [PORT_W-1:0] pd_o,
  output logic              irq_o
);
  ctl1_t             ctl1_q;
  ctl2_t             ctl2_q;
  logic [PORT_W-1:0] pd_q;
  logic              we1, we2, wepd;

  assign we1  = sel_i & wr_i & (addr_i == CTL1_ADDR);
  assign we2  = sel_i & wr_i & (addr_i == CTL2_ADDR);
  assign wepd = sel_i & wr_i & (addr_i == PD_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_q <= '0;
      ctl2_q <= '0;
      pd_q   <= '0;
    end else begin
      if (we1) begin
        ctl1_q      <= ctl1_t'(wdata_i);
        ctl1_q.flag <= wdata_i[0] | edge_i;  // hardware set wins
      end else if (edge_i) begin
        ctl1_q.flag <= 1'b1;
      end
      if (we2)  ctl2_q <= ctl2_t'(wdata_i[7:1]);
      if (wepd) pd_q   <= wdata_i[PORT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      if (addr_i == CTL1_ADDR)      rdata_o = ctl1_q;
      else if (addr_i == CTL2_ADDR) rdata_o = {ctl2_q, out_i};
      else if (addr_i == PD_ADDR)   rdata_o[PORT_W-1:0] = pd_q;
    end
  end

  assign ctl1_o = ctl1_q;
  assign ctl2_o = ctl2_q;
  assign pd_o   = pd_q;
  assign irq_o  = ctl1_q.flag & ctl1_q.ie;

  a_r10_hw_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> ctl1_q.flag);
  a_r2_flag_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl1_q.flag) |-> $past(edge_i || (we1 && wdata_i[0])));
  a_r9_off_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl1_q.on && !we1) |=> !$rose(ctl1_q.flag));
endmodule

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              cmp_raw_i,
  output logic              cmp_on_o,
  output logic [1:0]        ref_sel_o,
  output logic              ref_drive_o,
  output logic              ref_path0_o,
  output logic              ref_path1_o,
  output logic              in0_conn_o,
  output logic              in1_conn_o,
  output logic              in_swap_o,
  output logic [PORT_W-1:0] pad_in_dis_o,
  output logic              irq_o
);
  ctl1_t ctl1;
  ctl2_t ctl2;
  logic  cmp_out, cmp_edge;

  cmp_ctrl_regs #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .out_i   (cmp_out),
    .edge_i  (cmp_edge),
    .ctl1_o  (ctl1),
    .ctl2_o  (ctl2),
    .pd_o    (pad_in_dis_o),
    .irq_o   (irq_o)
  );

  cmp_ctrl_sampler #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sampler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .raw_i       (cmp_raw_i),
    .on_i        (ctl1.on),
    .filt_en_i   (ctl2.filt_en),
    .edge_fall_i (ctl1.edge_fall),
    .out_o       (cmp_out),
    .edge_o      (cmp_edge)
  );

  assign cmp_on_o    = ctl1.on;
  assign ref_sel_o   = ctl1.ref_sel;
  assign ref_drive_o = |ctl1.ref_sel;
  assign ref_path0_o = ref_drive_o & ~ctl1.route;
  assign ref_path1_o = ref_drive_o &  ctl1.route;
  assign in_swap_o   = ctl1.exch;
  assign in0_conn_o  = ctl2.conn0;
  assign in1_conn_o  = ctl2.conn1;

  a_r5_ref_one_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ref_path0_o, ref_path1_o}));
  a_r5_ref_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_sel_o == 2'd0) |-> !(ref_path0_o || ref_path1_o));
endmodule

// File: tb/cmp_ctrl_tb.sv
module cmp_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, raw = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata, pad;
  logic       on, drv, p0, p1, c0, c1, swp, irq;
  logic [1:0] rsel;
  int         checks = 0, errors = 0;

  localparam logic [7:0] A1 = 8'h59, A2 = 8'h5A, AP = 8'h5B;

  always #10 clk = ~clk;

  cmp_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cmp_raw_i(raw), .cmp_on_o(on),
    .ref_sel_o(rsel), .ref_drive_o(drv), .ref_path0_o(p0), .ref_path1_o(p1),
    .in0_conn_o(c0), .in1_conn_o(c1), .in_swap_o(swp), .pad_in_dis_o(pad),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(A1, d); chk("R1 ctl1", d, 8'h00);
    rd_reg(A2, d); chk("R1 ctl2", d, 8'h00);
    rd_reg(AP, d); chk("R1 pd", d, 8'h00);
    chk("R1 outputs", {on, drv, p0, p1, c0, c1, swp, irq}, 8'h00);
    chk("R1 pad", pad, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr_reg(A1, 8'hF4);
    rd_reg(A1, d); chk("R2 ctl1 readback", d, 8'hF4);
    chk("R5 ref3 route1", {rsel, drv, p0, p1}, {2'd3, 1'b1, 1'b0, 1'b1});
    chk("R11 swap", {7'd0, swp}, 8'h01);
    wr_reg(A1, 8'h14);
    chk("R5 ref1 route0", {rsel, drv, p0, p1}, {2'd1, 1'b1, 1'b1, 1'b0});
    chk("R11 swap off", {7'd0, swp}, 8'h00);
    wr_reg(A1, 8'h60);
    chk("R5 ref2 route1", {rsel, drv, p0, p1}, {2'd2, 1'b1, 1'b0, 1'b1});
    wr_reg(A1, 8'h40);
    chk("R5 ref off", {rsel, drv, p0, p1}, {2'd0, 1'b0, 1'b0, 1'b0});
    wr_reg(A2, 8'hFF);
    rd_reg(A2, d); chk("R3 ctl2 status read-only", d, 8'hFE);
    chk("R11 connects", {6'd0, c1, c0}, 8'h03);
    wr_reg(A2, 8'hA0);
    rd_reg(A2, d); chk("R3 spare storage", d, 8'hA0);
    chk("R11 connects off", {6'd0, c1, c0}, 8'h00);
    wr_reg(AP, 8'h5A);
    chk("R8 pad", pad, 8'h5A);
    rd_reg(AP, d); chk("R8 pd readback", d, 8'h5A);
    wr_reg(A2, 8'h00);
  endtask

  task automatic t_transparent;
    logic [7:0] d;
    wr_reg(A1, 8'h0A);
    chk("R11 power", {7'd0, on}, 8'h01);
    raw = 1'b1;
    wait_n(1);
    rd_reg(A2, d); chk("R6 status after 1 edge", {7'd0, d[0]}, 8'h00);
    wait_n(1);
    rd_reg(A2, d); chk("R6 status after 2 edges", {7'd0, d[0]}, 8'h01);
    chk("R6 flag not yet", {7'd0, irq}, 8'h00);
    wait_n(1);
    chk("R4 rising sets flag", {7'd0, irq}, 8'h01);
    rd_reg(A1, d); chk("R10 flag bit", d, 8'h0B);
  endtask

  task automatic t_clear_and_fall;
    wr_reg(A1, 8'h0A);
    chk("R10 software clear", {7'd0, irq}, 8'h00);
    raw = 1'b0;
    wait_n(5);
    chk("R4 falling ignored in rising mode", {7'd0, irq}, 8'h00);
    wr_reg(A1, 8'h0E);
    raw = 1'b1;
    wait_n(5);
    chk("R4 rising ignored in falling mode", {7'd0, irq}, 8'h00);
    raw = 1'b0;
    wait_n(4);
    chk("R4 falling sets flag", {7'd0, irq}, 8'h01);
    wr_reg(A1, 8'h0C);
    chk("R10 irq gated by enable", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_hw_wins;
    logic [7:0] d;
    wr_reg(A1, 8'h0B);
    chk("R10 software set", {7'd0, irq}, 8'h01);
    raw = 1'b1;
    wait_n(2);
    sel = 1'b1; wr = 1'b1; addr = A1; wdata = 8'h0A;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    rd_reg(A1, d); chk("R10 hardware set wins", d, 8'h0B);
  endtask

  task automatic t_filter;
    logic [7:0] d;
    wr_reg(A2, 8'h02);
    raw = 1'b0;
    wait_n(10);
    wr_reg(A1, 8'h0A);
    raw = 1'b1;
    wait_n(1);
    raw = 1'b0;
    wait_n(10);
    rd_reg(A2, d); chk("R7 glitch rejected", {7'd0, d[0]}, 8'h00);
    chk("R7 glitch no flag", {7'd0, irq}, 8'h00);
    raw = 1'b1;
    wait_n(3);
    rd_reg(A2, d); chk("R7 not yet stable", {7'd0, d[0]}, 8'h00);
    wait_n(3);
    rd_reg(A2, d); chk("R7 stable run passes", {7'd0, d[0]}, 8'h01);
    wait_n(2);
    chk("R7 filtered edge flags", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_off;
    logic [7:0] d;
    wr_reg(A2, 8'h00);
    wr_reg(A1, 8'h02);
    raw = 1'b1;
    wait_n(5);
    rd_reg(A2, d); chk("R9 status 0 when off", {7'd0, d[0]}, 8'h00);
    raw = 1'b0;
    wait_n(3);
    raw = 1'b1;
    wait_n(4);
    chk("R9 no flag when off", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset;
    t_regs;
    t_transparent;
    t_clear_and_fall;
    t_hw_wins;
    t_filter;
    t_off;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule